// File: doc/BRIEF.md
# Speculative Instruction Verifier

This block confirms, in program order, the instructions that a speculative thread has already executed. The producer pushes one record per instruction into an internal in-order buffer. Each record holds the program counter, an operation code, two source register numbers with the values the speculative thread read, a destination register number with the value it produced, and a memory address. The verifier owns the committed (non-speculative) register file. It does not re-execute anything. A record is accepted when the source values it carries equal the committed values, and then its recorded result is committed. Memory records also have their address checked, and loads also have their data checked against a read of committed memory.

Up to `LANES` records are confirmed per clock. Within one clock, a later record sees the destination values written by earlier records of the same group. Stores leave through a memory write port. Loads send a read request and stall verification until the response returns, so a slow (missing) read holds back everything behind it. On the first failing record the block raises a one-cycle mismatch pulse carrying that record's program counter. Records ahead of it in the group still commit, and the whole buffer is discarded so that the threads can resynchronise.

Top module: `spec_verifier`

## Requirements
- R1: Records are held in first-in first-out order in a buffer of `DEPTH` (default 128) entries. `push_ready` is low while the buffer is full and during a mismatch cycle, and a push is taken only when `push_valid` and `push_ready` are both high.
- R2: A record passes only when `push_rs1_val` and `push_rs2_val` equal the committed values of registers `push_rs1` and `push_rs2`. A passing non-store record whose destination is not register 0 writes its destination value into the committed register file, visible on an `rf_wr_*` lane in the cycle it commits.
- R3: Up to `LANES` (default 8) records commit in one cycle, in buffer order, on lanes 0 upward. Lane k's bits are `rf_wr_idx[k*5 +: 5]` and `rf_wr_data[k*32 +: 32]`. Source values of a record are compared against the results of earlier records in the same cycle.
- R4: Operation codes: 0 is a plain instruction, 1 is a load, 2 is a store, and 3 is treated as a plain instruction. A load or store passes only if its address equals its first source value. A passing store drives `st_valid` with `st_addr` set to the address and `st_data` set to the second source value, and it writes no register.
- R5: A load is confirmed only as the first record of a cycle's group. When a load reaches the head, `ld_req_valid` pulses once with the address. Nothing at or behind the load commits until `ld_rsp_valid` returns. The load passes only if `ld_rsp_data` equals its recorded destination value. At most one load or store is confirmed per cycle.
- R6: When a record fails, `mismatch` is high for exactly that cycle with `mismatch_pc` equal to its program counter. Earlier records of the group commit. The failing record and every later one are discarded, the buffer is empty in the next cycle, and later records that would have passed never commit.
- R7: Register 0 reads as zero in every comparison and is never written.
- R8: After reset the buffer is empty, every committed register is zero, and no write, store, load request or mismatch is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Producer offers a record |
| push_ready | output | 1 | Buffer can take a record this cycle |
| push_pc | input | 32 | Program counter of the record |
| push_op | input | 2 | Operation code (0 plain, 1 load, 2 store, 3 plain) |
| push_rs1 | input | 5 | First source register number |
| push_rs1_val | input | 32 | First source value seen speculatively |
| push_rs2 | input | 5 | Second source register number |
| push_rs2_val | input | 32 | Second source value seen speculatively |
| push_rd | input | 5 | Destination register number |
| push_rd_val | input | 32 | Destination value produced speculatively |
| push_addr | input | 32 | Memory address of a load or store |
| rf_wr_en | output | LANES | Per-lane committed register write enable |
| rf_wr_idx | output | LANES*5 | Per-lane destination register numbers |
| rf_wr_data | output | LANES*32 | Per-lane committed values |
| st_valid | output | 1 | Committed store this cycle |
| st_addr | output | 32 | Store address |
| st_data | output | 32 | Store data |
| ld_req_valid | output | 1 | Read request for the load at the head |
| ld_req_addr | output | 32 | Read request address |
| ld_rsp_valid | input | 1 | Read data is returned this cycle |
| ld_rsp_data | input | 32 | Returned committed memory word |
| mismatch | output | 1 | Failing record found; buffer discarded |
| mismatch_pc | output | 32 | Program counter of the failing record |

## Verification
The bench holds a load's read response back so that records pile up behind it. When the response is released, a full group commits in one cycle as a chain of dependent records. A design without same-cycle forwarding would flag a false mismatch on the second link, and one limited to fewer lanes would show a smaller peak group. A bad record placed between two good ones must leave the first committed and the third discarded. A design that skipped records instead of flushing would still commit the third. Further tests cover a store whose address disagrees with its base value, a load whose returned data differs from the record, a load that stalls the plain record behind it, two stores queued back to back, and a buffer filled to its depth. These catch missing address checks, missing data checks, overtaking past a pending read, merged stores and lost back-pressure.

// File: rtl/svf_pkg.sv
// Shared widths, operation codes and the buffer record layout for the
// speculative instruction verifier. Assumes address and data widths match.
package svf_pkg;
    parameter int XLEN = 32;
    parameter int PCW  = 32;
    parameter int AW   = 32;
    parameter int RIDW = 5;
    localparam int NREG = 1 << RIDW;

    typedef enum logic [1:0] {
        OP_PLAIN = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_SPARE = 2'b11
    } op_e;

    typedef struct packed {
        logic [PCW-1:0]  pc;
        op_e             op;
        logic [RIDW-1:0] rs1;
        logic [XLEN-1:0] rs1_val;
        logic [RIDW-1:0] rs2;
        logic [XLEN-1:0] rs2_val;
        logic [RIDW-1:0] rd;
        logic [XLEN-1:0] rd_val;
        logic [AW-1:0]   addr;
    } lab_entry_t;
endpackage

// File: rtl/svf_lab_fifo.sv
// In-order record buffer with one push and up to LANES pops per cycle.
// Exposes the oldest LANES records as read lanes. Assumes DEPTH is a power
// of two, that pops never exceed the occupancy, and that no push arrives in
// a flush cycle.
module svf_lab_fifo
    import svf_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int LANES = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int OW = $clog2(DEPTH + 1),
    localparam int CW = $clog2(LANES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       push,
    input  lab_entry_t push_ent,
    input  logic [CW-1:0] pop_n,
    output logic [OW-1:0] occ,
    output lab_entry_t lane_ent [LANES]
);
    lab_entry_t    mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;

    // Store the pushed record at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= push_ent;
        end
    end

    // Advance pointers and occupancy; a flush discards everything held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else if (flush) begin
            rptr <= wptr;
            occ  <= '0;
        end else begin
            wptr <= wptr + PW'(push);
            rptr <= rptr + PW'(pop_n);
            occ  <= occ + OW'(push) - OW'(pop_n);
        end
    end

    // Present the oldest LANES records, wrapping around the storage.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_ent[k] = mem[rptr + PW'(k)];
    end
endmodule

// File: rtl/svf_lane_check.sv
// Pass test for one record against the source values it must match.
// Assumes the caller supplies committed values already forwarded from
// earlier records of the same group.
module svf_lane_check
    import svf_pkg::*;
(
    input  op_e             op,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [RIDW-1:0] rd,
    input  logic [XLEN-1:0] rd_val,
    input  logic [AW-1:0]   addr,
    input  logic [XLEN-1:0] cur_rs1,
    input  logic [XLEN-1:0] cur_rs2,
    input  logic [XLEN-1:0] ld_data,
    output logic            pass,
    output logic            writes_rd,
    output logic            is_load,
    output logic            is_store
);
    logic src_ok;
    logic addr_ok;
    logic data_ok;

    // Compare recorded sources, address and load data with committed state.
    always_comb begin
        is_load   = (op == OP_LOAD);
        is_store  = (op == OP_STORE);
        src_ok    = (rs1_val == cur_rs1) && (rs2_val == cur_rs2);
        addr_ok   = !(is_load || is_store) || (addr == AW'(rs1_val));
        data_ok   = !is_load || (ld_data == rd_val);
        pass      = src_ok && addr_ok && data_ok;
        writes_rd = !is_store && (rd != '0);
    end
endmodule

// File: rtl/svf_arch_regs.sv
// Committed register file written by up to LANES lanes per cycle.
// Assumes lanes are in program order, so a later lane wins on a clash.
// Register 0 is held at zero.
module svf_arch_regs
    import svf_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        wr_en,
    input  logic [LANES*RIDW-1:0]   wr_idx,
    input  logic [LANES*XLEN-1:0]   wr_data,
    output logic [XLEN-1:0]         rf_q [NREG]
);
    // Apply the group's writes in lane order; keep register 0 at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                rf_q[i] <= '0;
            end
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (wr_en[k] && (wr_idx[k*RIDW +: RIDW] != '0)) begin
                    rf_q[wr_idx[k*RIDW +: RIDW]] <= wr_data[k*XLEN +: XLEN];
                end
            end
        end
    end
endmodule

// File: rtl/spec_verifier.sv
// Top of the speculative instruction verifier. It drains the record buffer
// in order, up to LANES records per cycle, forwarding results within the
// group. It allows one load or store per cycle, with a load only at the
// head and only when its read response is present. It stops at the first
// failing record, pulses mismatch and flushes the buffer. Assumes the
// memory responds no earlier than the cycle after a request.
module spec_verifier
    import svf_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int LANES = 8,
    localparam int OW = $clog2(DEPTH + 1),
    localparam int CW = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_valid,
    output logic                  push_ready,
    input  logic [31:0]           push_pc,
    input  logic [1:0]            push_op,
    input  logic [4:0]            push_rs1,
    input  logic [31:0]           push_rs1_val,
    input  logic [4:0]            push_rs2,
    input  logic [31:0]           push_rs2_val,
    input  logic [4:0]            push_rd,
    input  logic [31:0]           push_rd_val,
    input  logic [31:0]           push_addr,
    output logic [LANES-1:0]      rf_wr_en,
    output logic [LANES*5-1:0]    rf_wr_idx,
    output logic [LANES*32-1:0]   rf_wr_data,
    output logic                  st_valid,
    output logic [31:0]           st_addr,
    output logic [31:0]           st_data,
    output logic                  ld_req_valid,
    output logic [31:0]           ld_req_addr,
    input  logic                  ld_rsp_valid,
    input  logic [31:0]           ld_rsp_data,
    output logic                  mismatch,
    output logic [31:0]           mismatch_pc
);
    lab_entry_t      push_ent;
    lab_entry_t      lane_ent [LANES];
    logic [OW-1:0]   occ;
    logic [CW-1:0]   pop_n;
    logic            waiting;
    logic            rsp_here;
    logic [XLEN-1:0] rf_q [NREG];
    logic [XLEN-1:0] cur1 [LANES];
    logic [XLEN-1:0] cur2 [LANES];
    logic [LANES-1:0] pass;
    logic [LANES-1:0] writes_rd;
    logic [LANES-1:0] is_load;
    logic [LANES-1:0] is_store;
    logic [LANES-1:0] commit;

    // Pack the producer's fields into one record.
    always_comb begin
        push_ent.pc      = push_pc;
        push_ent.op      = op_e'(push_op);
        push_ent.rs1     = push_rs1;
        push_ent.rs1_val = push_rs1_val;
        push_ent.rs2     = push_rs2;
        push_ent.rs2_val = push_rs2_val;
        push_ent.rd      = push_rd;
        push_ent.rd_val  = push_rd_val;
        push_ent.addr    = push_addr;
    end

    assign push_ready = (occ != OW'(DEPTH)) && !mismatch;

    svf_lab_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (mismatch),
        .push     (push_valid && push_ready),
        .push_ent (push_ent),
        .pop_n    (pop_n),
        .occ      (occ),
        .lane_ent (lane_ent)
    );

    svf_arch_regs #(.LANES(LANES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rf_wr_en),
        .wr_idx  (rf_wr_idx),
        .wr_data (rf_wr_data),
        .rf_q    (rf_q)
    );

    // Committed source values per lane, overridden by earlier lanes' results.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            cur1[k] = (lane_ent[k].rs1 == '0) ? '0 : rf_q[lane_ent[k].rs1];
            cur2[k] = (lane_ent[k].rs2 == '0) ? '0 : rf_q[lane_ent[k].rs2];
            for (int j = 0; j < k; j++) begin
                if (writes_rd[j] && (lane_ent[j].rd == lane_ent[k].rs1)) begin
                    cur1[k] = lane_ent[j].rd_val;
                end
                if (writes_rd[j] && (lane_ent[j].rd == lane_ent[k].rs2)) begin
                    cur2[k] = lane_ent[j].rd_val;
                end
            end
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        svf_lane_check u_chk (
            .op        (lane_ent[k].op),
            .rs1_val   (lane_ent[k].rs1_val),
            .rs2_val   (lane_ent[k].rs2_val),
            .rd        (lane_ent[k].rd),
            .rd_val    (lane_ent[k].rd_val),
            .addr      (lane_ent[k].addr),
            .cur_rs1   (cur1[k]),
            .cur_rs2   (cur2[k]),
            .ld_data   (ld_rsp_data),
            .pass      (pass[k]),
            .writes_rd (writes_rd[k]),
            .is_load   (is_load[k]),
            .is_store  (is_store[k])
        );
    end

    assign rsp_here     = waiting && ld_rsp_valid;
    assign ld_req_valid = (occ != '0) && is_load[0] && !waiting;
    assign ld_req_addr  = lane_ent[0].addr;

    // Track the single outstanding read for the load at the head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting <= 1'b0;
        end else if (ld_req_valid) begin
            waiting <= 1'b1;
        end else if (rsp_here) begin
            waiting <= 1'b0;
        end
    end

    // Walk the lanes in order, forming the group and finding the first failure.
    always_comb begin
        logic go;
        logic mem_seen;
        go          = 1'b1;
        mem_seen    = 1'b0;
        pop_n       = '0;
        commit      = '0;
        mismatch    = 1'b0;
        mismatch_pc = '0;
        st_valid    = 1'b0;
        st_addr     = '0;
        st_data     = '0;
        for (int k = 0; k < LANES; k++) begin
            if (go) begin
                if (k >= int'(occ)) begin
                    go = 1'b0;
                end else if (is_load[k] && ((k != 0) || !rsp_here)) begin
                    go = 1'b0;
                end else if ((is_load[k] || is_store[k]) && mem_seen) begin
                    go = 1'b0;
                end else if (pass[k]) begin
                    commit[k] = 1'b1;
                    pop_n     = pop_n + CW'(1);
                    if (is_load[k] || is_store[k]) begin
                        mem_seen = 1'b1;
                    end
                    if (is_store[k]) begin
                        st_valid = 1'b1;
                        st_addr  = lane_ent[k].addr;
                        st_data  = lane_ent[k].rs2_val;
                    end
                end else begin
                    mismatch    = 1'b1;
                    mismatch_pc = lane_ent[k].pc;
                    go          = 1'b0;
                end
            end
        end
    end

    // Drive the per-lane committed register writes.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            rf_wr_en[k]                = commit[k] && writes_rd[k];
            rf_wr_idx[k*RIDW +: RIDW]  = lane_ent[k].rd;
            rf_wr_data[k*XLEN +: XLEN] = lane_ent[k].rd_val;
        end
    end
endmodule

// File: rtl/svf_checker.sv
// Protocol properties of the verifier, attached to every instance by bind.
// Assumes it observes the buffer occupancy of the top it is bound to.
module svf_checker #(
    parameter int DEPTH = 128,
    parameter int LANES = 8,
    localparam int OW = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mismatch,
    input logic               push_ready,
    input logic               ld_req_valid,
    input logic [LANES-1:0]   rf_wr_en,
    input logic [LANES*5-1:0] rf_wr_idx,
    input logic [OW-1:0]      occ
);
    logic r0_hit;

    // Flag any lane that would write register 0.
    always_comb begin
        r0_hit = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (rf_wr_en[k] && (rf_wr_idx[k*5 +: 5] == 5'd0)) begin
                r0_hit = 1'b1;
            end
        end
    end

    AST_FULL_STALLS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OW'(DEPTH)) |-> !push_ready); // R1
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> (occ == '0)); // R6
    AST_MISMATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> !mismatch); // R6
    AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !r0_hit); // R7
    AST_ONE_READ_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req_valid |=> !ld_req_valid); // R5
endmodule

bind spec_verifier svf_checker #(.DEPTH(DEPTH), .LANES(LANES)) u_svf_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mismatch     (mismatch),
    .push_ready   (push_ready),
    .ld_req_valid (ld_req_valid),
    .rf_wr_en     (rf_wr_en),
    .rf_wr_idx    (rf_wr_idx),
    .occ          (occ)
);

// File: tb/tb_spec_verifier.sv
`timescale 1ns/1ps
module tb_spec_verifier;
    localparam int DEPTH = 128;
    localparam int LANES = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0;
    logic push_ready;
    logic [31:0] push_pc = '0;
    logic [1:0]  push_op = '0;
    logic [4:0]  push_rs1 = '0, push_rs2 = '0, push_rd = '0;
    logic [31:0] push_rs1_val = '0, push_rs2_val = '0, push_rd_val = '0, push_addr = '0;
    logic [LANES-1:0]    rf_wr_en;
    logic [LANES*5-1:0]  rf_wr_idx;
    logic [LANES*32-1:0] rf_wr_data;
    logic st_valid;
    logic [31:0] st_addr, st_data;
    logic ld_req_valid;
    logic [31:0] ld_req_addr;
    logic ld_rsp_valid = 1'b0;
    logic [31:0] ld_rsp_data = '0;
    logic mismatch;
    logic [31:0] mismatch_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] obs_regs [32];
    logic [31:0] bmem [64];
    int wr_total = 0;
    int st_total = 0;
    int mm_total = 0;
    int max_grp = 0;
    logic [31:0] last_mm_pc = '0;
    logic [31:0] last_st_addr = '0, last_st_data = '0;
    bit pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int dly = 0;
    int lat = 0;
    bit hold = 1'b0;

    spec_verifier #(.DEPTH(DEPTH), .LANES(LANES)) dut (.*);

    always #2.5 clk = ~clk;

    // Monitor: record committed writes, stores, mismatches and read requests.
    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones(rf_wr_en) > max_grp) max_grp = $countones(rf_wr_en);
            for (int k = 0; k < LANES; k++) begin
                if (rf_wr_en[k]) begin
                    obs_regs[rf_wr_idx[k*5 +: 5]] = rf_wr_data[k*32 +: 32];
                    wr_total++;
                end
            end
            if (st_valid) begin
                st_total++;
                last_st_addr = st_addr;
                last_st_data = st_data;
                bmem[st_addr[5:0]] = st_data;
            end
            if (mismatch) begin
                mm_total++;
                last_mm_pc = mismatch_pc;
            end
            if (ld_req_valid) begin
                pend = 1'b1;
                pend_addr = ld_req_addr;
                dly = lat;
            end
        end
    end

    // Memory responder with programmable latency and a hold switch.
    always @(posedge clk) begin
        #1;
        ld_rsp_valid = 1'b0;
        if (pend && !hold) begin
            if (dly == 0) begin
                ld_rsp_valid = 1'b1;
                ld_rsp_data = bmem[pend_addr[5:0]];
                pend = 1'b0;
            end else begin
                dly--;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic push(input logic [31:0] pc, input logic [1:0] op,
                        input logic [4:0] rs1, input logic [31:0] v1,
                        input logic [4:0] rs2, input logic [31:0] v2,
                        input logic [4:0] rd, input logic [31:0] vd,
                        input logic [31:0] addr);
        @(posedge clk); #1;
        push_valid = 1'b1; push_pc = pc; push_op = op;
        push_rs1 = rs1; push_rs1_val = v1; push_rs2 = rs2; push_rs2_val = v2;
        push_rd = rd; push_rd_val = vd; push_addr = addr;
        forever begin
            @(negedge clk);
            if (push_ready) break;
        end
        @(posedge clk); #1;
        push_valid = 1'b0;
    endtask

    task automatic set_hold(input bit h);
        @(negedge clk);
        hold = h;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(push_ready == 1'b1, "R8 ready after reset", {31'b0, push_ready}, 32'd1);
        check(rf_wr_en == '0 && !st_valid && !ld_req_valid && !mismatch,
              "R8 quiet after reset", {24'b0, rf_wr_en}, 32'd0);
    endtask

    task automatic t_basic();
        push(32'h100, 2'd0, 5'd0, 0, 5'd0, 0, 5'd5, 32'h55, 0);
        push(32'h104, 2'd0, 5'd5, 32'h55, 5'd0, 0, 5'd6, 32'h66, 0);
        cycles(4);
        check(obs_regs[5] == 32'h55, "R2 write r5", obs_regs[5], 32'h55);
        check(obs_regs[6] == 32'h66, "R2 dependent write r6", obs_regs[6], 32'h66);
    endtask

    task automatic t_src_mismatch();
        int m0 = mm_total;
        push(32'h400, 2'd0, 5'd5, 32'h99, 5'd0, 0, 5'd7, 32'h77, 0);
        cycles(4);
        check(mm_total == m0 + 1, "R6 one mismatch pulse", mm_total, m0 + 1);
        check(last_mm_pc == 32'h400, "R6 mismatch pc", last_mm_pc, 32'h400);
        check(obs_regs[7] == 0, "R2 failing record not written", obs_regs[7], 0);
    endtask

    task automatic t_reg_zero();
        int w0 = wr_total;
        int m0 = mm_total;
        push(32'h500, 2'd0, 5'd0, 0, 5'd0, 0, 5'd0, 32'h7, 0);
        cycles(4);
        check(wr_total == w0 && mm_total == m0, "R7 no write to r0", wr_total, w0);
        push(32'h504, 2'd0, 5'd0, 32'h5, 5'd0, 0, 5'd8, 32'h8, 0);
        cycles(4);
        check(mm_total == m0 + 1 && last_mm_pc == 32'h504, "R7 r0 reads zero", last_mm_pc, 32'h504);
    endtask

    task automatic t_group();
        set_hold(1'b1);
        push(32'h600, 2'd1, 5'd0, 0, 5'd0, 0, 5'd1, 32'h100, 32'h0);
        for (int i = 1; i <= 9; i++) begin
            push(32'h600 + 4*i, 2'd0, 5'(i), 32'h100 + i - 1, 5'd0, 0, 5'(i + 1), 32'h100 + i, 0);
        end
        cycles(3);
        max_grp = 0;
        set_hold(1'b0);
        cycles(8);
        check(max_grp == LANES, "R3 full group in one cycle", max_grp, LANES);
        check(obs_regs[10] == 32'h109, "R3 forwarded chain end r10", obs_regs[10], 32'h109);
        check(obs_regs[8] == 32'h107, "R3 chain r8", obs_regs[8], 32'h107);
    endtask

    task automatic t_store();
        int s0 = st_total;
        int m0 = mm_total;
        push(32'h700, 2'd2, 5'd2, 32'h101, 5'd3, 32'h102, 5'd9, 32'h0, 32'h101);
        cycles(4);
        check(st_total == s0 + 1 && last_st_addr == 32'h101, "R4 store address", last_st_addr, 32'h101);
        check(last_st_data == 32'h102, "R4 store data", last_st_data, 32'h102);
        check(obs_regs[9] == 32'h108, "R4 store writes no register", obs_regs[9], 32'h108);
        push(32'h704, 2'd2, 5'd2, 32'h101, 5'd3, 32'h102, 5'd0, 0, 32'h104);
        cycles(4);
        check(st_total == s0 + 1 && mm_total == m0 + 1, "R4 bad address store rejected", st_total, s0 + 1);
        check(last_mm_pc == 32'h704, "R4 bad address pc", last_mm_pc, 32'h704);
    endtask

    task automatic t_load();
        int m0 = mm_total;
        int w0;
        lat = 4;
        push(32'h800, 2'd1, 5'd2, 32'h101, 5'd0, 0, 5'd11, 32'h102, 32'h101);
        cycles(10);
        check(obs_regs[11] == 32'h102, "R5 load sees stored word", obs_regs[11], 32'h102);
        push(32'h804, 2'd1, 5'd2, 32'h101, 5'd0, 0, 5'd12, 32'h999, 32'h101);
        cycles(10);
        check(mm_total == m0 + 1 && last_mm_pc == 32'h804, "R5 load data mismatch", last_mm_pc, 32'h804);
        check(obs_regs[12] == 0, "R5 bad load not written", obs_regs[12], 0);
        lat = 0;
        set_hold(1'b1);
        push(32'h810, 2'd1, 5'd2, 32'h101, 5'd0, 0, 5'd13, 32'h102, 32'h101);
        push(32'h814, 2'd0, 5'd0, 0, 5'd0, 0, 5'd14, 32'h77, 0);
        w0 = wr_total;
        cycles(10);
        check(wr_total == w0 && obs_regs[14] == 0, "R5 pending read blocks later record", obs_regs[14], 0);
        set_hold(1'b0);
        cycles(4);
        check(obs_regs[13] == 32'h102 && obs_regs[14] == 32'h77, "R5 released load and follower", obs_regs[14], 32'h77);
    endtask

    task automatic t_partial();
        int m0 = mm_total;
        set_hold(1'b1);
        push(32'h900, 2'd1, 5'd0, 0, 5'd0, 0, 5'd0, 32'h100, 32'h0);
        push(32'h904, 2'd0, 5'd0, 0, 5'd0, 0, 5'd15, 32'h15, 0);
        push(32'h908, 2'd0, 5'd2, 32'hdead, 5'd0, 0, 5'd17, 32'h17, 0);
        push(32'h90c, 2'd0, 5'd0, 0, 5'd0, 0, 5'd16, 32'h16, 0);
        cycles(2);
        set_hold(1'b0);
        cycles(6);
        check(obs_regs[15] == 32'h15, "R6 earlier record commits", obs_regs[15], 32'h15);
        check(mm_total == m0 + 1 && last_mm_pc == 32'h908, "R6 failing pc in group", last_mm_pc, 32'h908);
        check(obs_regs[16] == 0, "R6 later record discarded", obs_regs[16], 0);
        check(push_ready == 1'b1, "R6 buffer usable after flush", {31'b0, push_ready}, 1);
    endtask

    task automatic t_two_stores();
        int s0 = st_total;
        set_hold(1'b1);
        push(32'ha00, 2'd1, 5'd0, 0, 5'd0, 0, 5'd0, 32'h100, 32'h0);
        push(32'ha04, 2'd2, 5'd4, 32'h103, 5'd5, 32'h104, 5'd0, 0, 32'h103);
        push(32'ha08, 2'd2, 5'd5, 32'h104, 5'd6, 32'h105, 5'd0, 0, 32'h104);
        cycles(2);
        set_hold(1'b0);
        cycles(6);
        check(st_total == s0 + 2, "R4 both stores issued", st_total, s0 + 2);
        check(bmem[3] == 32'h104 && bmem[4] == 32'h105, "R5 one memory op per cycle", bmem[4], 32'h105);
    endtask

    task automatic t_full();
        set_hold(1'b1);
        push(32'hb00, 2'd1, 5'd0, 0, 5'd0, 0, 5'd0, 32'h100, 32'h0);
        for (int i = 1; i < DEPTH; i++) begin
            push(32'hb00 + 4*i, 2'd0, 5'd0, 0, 5'd0, 0, 5'd0, 0, 0);
        end
        @(negedge clk);
        check(push_ready == 1'b0, "R1 full buffer stalls producer", {31'b0, push_ready}, 0);
        set_hold(1'b0);
        cycles(30);
        @(negedge clk);
        check(push_ready == 1'b1, "R1 ready after drain", {31'b0, push_ready}, 1);
        push(32'hc00, 2'd0, 5'd0, 0, 5'd0, 0, 5'd18, 32'h18, 0);
        cycles(4);
        check(obs_regs[18] == 32'h18, "R1 in-order service after fill", obs_regs[18], 32'h18);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) obs_regs[i] = '0;
        for (int i = 0; i < 64; i++) bmem[i] = 32'h100 + i;
        cycles(4);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_src_mismatch();
        t_reg_zero();
        t_group();
        t_store();
        t_load();
        t_partial();
        t_two_stores();
        t_full();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule